// File: doc/BRIEF.md
# Relative Branch and Skip Next-PC Unit

This block decides where a byte-addressed core with 2-byte instruction words fetches next. It receives the address of the current instruction, an operation code for the branch, call or skip being executed, the raw offset field, the four arithmetic flags, and the data operands that skip decisions depend on. From these it produces the next fetch address, a strobe that squashes the following instruction, and a push request that carries the return address of a relative call.

Three families of operation are handled. The relative branches are unconditional, or depend on one flag in one polarity, with eight flag tests in all. The relative call is a branch that also pushes a return address. The skips are decided by comparing a file operand with the working register, by the zero state of an incremented or decremented value, by a zero test on the file operand, or by one selected bit of it. Every result is registered, so it appears one clock after the request. The return stack, instruction fetch and absolute jumps belong to the neighbouring logic.

Top module: `pc_npc_top`

## Requirements
- R1: A taken relative branch produces `next_pc_o = pc_i + 2 + 2*sext(offset)`, with the offset a signed word count.
- R2: The conditional branch codes are 1 (C set), 2 (C clear), 3 (N set), 4 (N clear), 5 (OV set), 6 (OV clear), 7 (Z set) and 8 (Z clear). The flags come in as `flags_i = {N, OV, Z, C}`. A branch whose condition fails gives `pc_i + 2`.
- R3: The conditional branches use only `off_i[7:0]` as a signed offset. The unconditional branch (code 9) and the relative call (code 10) use all of `off_i[10:0]`.
- R4: The relative call (code 10) asserts `push_o` with `ret_addr_o = pc_i + 2` and jumps as in R1. No other code asserts `push_o`.
- R5: The compare skips treat operands as unsigned. Code 11 skips when file equals W, code 12 when file is greater than W, and code 13 when file is less than W.
- R6: The counter skips test `cnt_i`. Codes 14 (decrement) and 16 (increment) skip when it is zero. Codes 15 (decrement) and 17 (increment) skip when it is nonzero.
- R7: Code 18 skips when the file operand is zero. Code 19 skips when bit `bit_sel_i` of the file operand is clear, and code 20 skips when that bit is set.
- R8: Whether or not a skip fires, a skip code gives `next_pc_o = pc_i + 2`. When the skip fires, `skip_o` is high for one cycle.
- R9: Code 0 and the unused codes 21 to 31 advance by 2 with no strobe. While `valid_i` is low, `valid_o`, `skip_o` and `push_o` are low and `next_pc_o` holds its value.
- R10: Outputs appear one clock after the request is sampled. An asynchronous reset clears every output to zero.
- R11: All PC arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 5 | Branch/call/skip operation code |
| pc_i | input | AW | Address of the current instruction |
| off_i | input | 11 | Raw signed word offset field |
| flags_i | input | 4 | Flags {N, OV, Z, C} |
| file_i | input | DW | File operand |
| wreg_i | input | DW | Working register |
| cnt_i | input | DW | Incremented or decremented file value |
| bit_sel_i | input | $clog2(DW) | Bit index for the bit tests |
| valid_o | output | 1 | Registered result present |
| next_pc_o | output | AW | Next fetch address |
| skip_o | output | 1 | Squash the next instruction |
| push_o | output | 1 | Push the return address |
| ret_addr_o | output | AW | Return address for a relative call |

## Verification
The bench builds the block with its default values: a 21-bit address, an 8-bit data path, and offsets of 8 and 11 bits. With a 21-bit address, the wrap in both directions can be reached from the top and bottom of the space. The 8-bit data path makes the signed-against-unsigned difference in the compare skips visible at the 0x7F/0x80 boundary. The 11-bit offset field lets a single value separate the short offset from the long one, so a conditional branch that wrongly reads the upper offset bits lands somewhere else.

// File: rtl/pc_npc_pkg.sv
package pc_npc_pkg;
  typedef enum logic [4:0] {
    OP_NONE    = 5'd0,
    OP_BR_C    = 5'd1,
    OP_BR_NC   = 5'd2,
    OP_BR_N    = 5'd3,
    OP_BR_NN   = 5'd4,
    OP_BR_OV   = 5'd5,
    OP_BR_NOV  = 5'd6,
    OP_BR_Z    = 5'd7,
    OP_BR_NZ   = 5'd8,
    OP_BRA     = 5'd9,
    OP_RCALL   = 5'd10,
    OP_CMP_EQ  = 5'd11,
    OP_CMP_GT  = 5'd12,
    OP_CMP_LT  = 5'd13,
    OP_DEC_SZ  = 5'd14,
    OP_DEC_SNZ = 5'd15,
    OP_INC_SZ  = 5'd16,
    OP_INC_SNZ = 5'd17,
    OP_TST_SZ  = 5'd18,
    OP_BIT_SC  = 5'd19,
    OP_BIT_SS  = 5'd20
  } npc_op_e;

  // flag vector layout {N, OV, Z, C}
  localparam int unsigned FL_C  = 0;
  localparam int unsigned FL_Z  = 1;
  localparam int unsigned FL_OV = 2;
  localparam int unsigned FL_N  = 3;
endpackage

// File: rtl/pc_npc_cond.sv
module pc_npc_cond
  import pc_npc_pkg::*;
(
  input  logic [4:0] op_i,
  input  logic [3:0] flags_i,
  output logic       cond_br_o,
  output logic       taken_o
);
  always_comb begin
    cond_br_o = 1'b1;
    taken_o   = 1'b0;
    case (op_i)
      OP_BR_C:   taken_o =  flags_i[FL_C];
      OP_BR_NC:  taken_o = ~flags_i[FL_C];
      OP_BR_N:   taken_o =  flags_i[FL_N];
      OP_BR_NN:  taken_o = ~flags_i[FL_N];
      OP_BR_OV:  taken_o =  flags_i[FL_OV];
      OP_BR_NOV: taken_o = ~flags_i[FL_OV];
      OP_BR_Z:   taken_o =  flags_i[FL_Z];
      OP_BR_NZ:  taken_o = ~flags_i[FL_Z];
      default:   cond_br_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pc_npc_skip.sv
module pc_npc_skip
  import pc_npc_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] file_i,
  input  logic [DW-1:0] wreg_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [BW-1:0] bit_sel_i,
  output logic          skip_op_o,
  output logic          skip_o
);
  logic cnt_zero, file_zero, sel_bit;

  assign cnt_zero  = (cnt_i == '0);
  assign file_zero = (file_i == '0);
  assign sel_bit   = file_i[bit_sel_i];

  always_comb begin
    skip_op_o = 1'b1;
    skip_o    = 1'b0;
    case (op_i)
      OP_CMP_EQ:  skip_o = (file_i == wreg_i);
      OP_CMP_GT:  skip_o = (file_i >  wreg_i);
      OP_CMP_LT:  skip_o = (file_i <  wreg_i);
      OP_DEC_SZ,
      OP_INC_SZ:  skip_o = cnt_zero;
      OP_DEC_SNZ,
      OP_INC_SNZ: skip_o = ~cnt_zero;
      OP_TST_SZ:  skip_o = file_zero;
      OP_BIT_SC:  skip_o = ~sel_bit;
      OP_BIT_SS:  skip_o = sel_bit;
      default:    skip_op_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pc_npc_target.sv
module pc_npc_target #(
  parameter int unsigned AW    = 21,
  parameter int unsigned OFF_W = 8
) (
  input  logic [AW-1:0]    pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [AW-1:0]    tgt_o
);
  logic [AW-1:0] off_ext, off_dbl;

  assign off_ext = {{(AW-OFF_W){off_i[OFF_W-1]}}, off_i};
  assign off_dbl = {off_ext[AW-2:0], 1'b0};
  assign tgt_o   = pc_i + AW'(2) + off_dbl;
endmodule

// File: rtl/pc_npc_top.sv
module pc_npc_top
  import pc_npc_pkg::*;
#(
  parameter int unsigned AW     = 21,
  parameter int unsigned DW     = 8,
  parameter int unsigned SOFF_W = 8,
  parameter int unsigned LOFF_W = 11,
  localparam int unsigned BW    = $clog2(DW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [4:0]        op_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [LOFF_W-1:0] off_i,
  input  logic [3:0]        flags_i,
  input  logic [DW-1:0]     file_i,
  input  logic [DW-1:0]     wreg_i,
  input  logic [DW-1:0]     cnt_i,
  input  logic [BW-1:0]     bit_sel_i,
  output logic              valid_o,
  output logic [AW-1:0]     next_pc_o,
  output logic              skip_o,
  output logic              push_o,
  output logic [AW-1:0]     ret_addr_o
);
  localparam int unsigned NTGT = 2;

  logic [AW-1:0] tgt [NTGT];
  logic [AW-1:0] seq_pc, npc_d;
  logic          cond_br, cond_taken, skip_op, skip_hit;
  logic          is_long, is_call;

  // index 0: short (conditional) offset, index 1: long (bra/call) offset
  for (genvar g = 0; g < NTGT; g++) begin : g_tgt
    localparam int unsigned OW = (g == 0) ? SOFF_W : LOFF_W;
    pc_npc_target #(.AW(AW), .OFF_W(OW)) u_tgt (
      .pc_i  (pc_i),
      .off_i (off_i[OW-1:0]),
      .tgt_o (tgt[g])
    );
  end

  pc_npc_cond u_cond (
    .op_i      (op_i),
    .flags_i   (flags_i),
    .cond_br_o (cond_br),
    .taken_o   (cond_taken)
  );

  pc_npc_skip #(.DW(DW)) u_skip (
    .op_i      (op_i),
    .file_i    (file_i),
    .wreg_i    (wreg_i),
    .cnt_i     (cnt_i),
    .bit_sel_i (bit_sel_i),
    .skip_op_o (skip_op),
    .skip_o    (skip_hit)
  );

  assign seq_pc  = pc_i + AW'(2);
  assign is_call = (op_i == OP_RCALL);
  assign is_long = (op_i == OP_BRA) || is_call;

  always_comb begin
    npc_d = seq_pc;
    if (is_long)                    npc_d = tgt[1];
    else if (cond_br && cond_taken) npc_d = tgt[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      next_pc_o  <= '0;
      skip_o     <= 1'b0;
      push_o     <= 1'b0;
      ret_addr_o <= '0;
    end else begin
      valid_o <= valid_i;
      skip_o  <= valid_i && skip_op && skip_hit;
      push_o  <= valid_i && is_call;
      if (valid_i) begin
        next_pc_o  <= npc_d;
        ret_addr_o <= seq_pc;
      end
    end
  end
endmodule

// File: rtl/pc_npc_chk.sv
module pc_npc_chk #(
  parameter int unsigned AW = 21
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [4:0]    op_i,
  input logic [AW-1:0] pc_i,
  input logic          valid_o,
  input logic [AW-1:0] next_pc_o,
  input logic          skip_o,
  input logic          push_o,
  input logic [AW-1:0] ret_addr_o
);
  logic [AW-1:0] pc_q;
  logic [4:0]    op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      op_q <= '0;
    end else begin
      pc_q <= pc_i;
      op_q <= op_i;
    end
  end

  // R8
  skip_push_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(skip_o && push_o));

  // R8
  skip_seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> (next_pc_o == pc_q + AW'(2)));

  // R4
  push_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (ret_addr_o == pc_q + AW'(2)) && (op_q == 5'd10));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!skip_o && !push_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(next_pc_o));

  // R10
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

bind pc_npc_top pc_npc_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .pc_i       (pc_i),
  .valid_o    (valid_o),
  .next_pc_o  (next_pc_o),
  .skip_o     (skip_o),
  .push_o     (push_o),
  .ret_addr_o (ret_addr_o)
);

// File: tb/pc_npc_top_bench.sv
module pc_npc_top_bench;
  localparam int AW = 21;
  localparam int DW = 8;

  typedef struct packed {
    logic [4:0]    op;
    logic [AW-1:0] pc;
    logic [10:0]   off;
    logic [3:0]    fl;   // {N, OV, Z, C}
    logic [DW-1:0] file;
    logic [DW-1:0] w;
    logic [DW-1:0] cnt;
    logic [2:0]    bsel;
    logic [AW-1:0] epc;
    logic          eskip;
    logic          epush;
    logic [7:0]    rq;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    // R1 R2 conditional branches
    '{5'd1,  21'h100,    11'h005, 4'b0001, 8'h00, 8'h00, 8'h01, 3'd0, 21'h10C,    1'b0, 1'b0, 8'd2},
    '{5'd1,  21'h100,    11'h005, 4'b0000, 8'h00, 8'h00, 8'h01, 3'd0, 21'h102,    1'b0, 1'b0, 8'd2},
    '{5'd2,  21'h100,    11'h0FE, 4'b0000, 8'h00, 8'h00, 8'h01, 3'd0, 21'h0FE,    1'b0, 1'b0, 8'd2},
    '{5'd3,  21'h100,    11'h07F, 4'b1000, 8'h00, 8'h00, 8'h01, 3'd0, 21'h200,    1'b0, 1'b0, 8'd2},
    '{5'd4,  21'h100,    11'h07F, 4'b1000, 8'h00, 8'h00, 8'h01, 3'd0, 21'h102,    1'b0, 1'b0, 8'd2},
    '{5'd5,  21'h1000,   11'h080, 4'b0100, 8'h00, 8'h00, 8'h01, 3'd0, 21'hF02,    1'b0, 1'b0, 8'd1},
    '{5'd6,  21'h1000,   11'h001, 4'b0000, 8'h00, 8'h00, 8'h01, 3'd0, 21'h1004,   1'b0, 1'b0, 8'd2},
    '{5'd7,  21'h200,    11'h010, 4'b0010, 8'h00, 8'h00, 8'h01, 3'd0, 21'h222,    1'b0, 1'b0, 8'd2},
    '{5'd8,  21'h200,    11'h010, 4'b0010, 8'h00, 8'h00, 8'h01, 3'd0, 21'h202,    1'b0, 1'b0, 8'd2},
    // R3 short offset ignores off[10:8]
    '{5'd7,  21'h200,    11'h7F0, 4'b0010, 8'h00, 8'h00, 8'h01, 3'd0, 21'h1E2,    1'b0, 1'b0, 8'd3},
    // R3 long offset
    '{5'd9,  21'h400,    11'h3FF, 4'b0000, 8'h00, 8'h00, 8'h01, 3'd0, 21'hC00,    1'b0, 1'b0, 8'd3},
    '{5'd9,  21'h1000,   11'h400, 4'b0000, 8'h00, 8'h00, 8'h01, 3'd0, 21'h802,    1'b0, 1'b0, 8'd3},
    // R11 wrap down and up
    '{5'd9,  21'h0,      11'h7FE, 4'b0000, 8'h00, 8'h00, 8'h01, 3'd0, 21'h1FFFFE, 1'b0, 1'b0, 8'd11},
    '{5'd9,  21'h1FFFFE, 11'h000, 4'b0000, 8'h00, 8'h00, 8'h01, 3'd0, 21'h0,      1'b0, 1'b0, 8'd11},
    // R4 relative call
    '{5'd10, 21'h300,    11'h010, 4'b0000, 8'h00, 8'h00, 8'h01, 3'd0, 21'h322,    1'b0, 1'b1, 8'd4},
    // R5 compares
    '{5'd11, 21'h100,    11'h000, 4'b0000, 8'h5A, 8'h5A, 8'h01, 3'd0, 21'h102,    1'b1, 1'b0, 8'd5},
    '{5'd11, 21'h100,    11'h000, 4'b0000, 8'h5A, 8'h5B, 8'h01, 3'd0, 21'h102,    1'b0, 1'b0, 8'd5},
    '{5'd12, 21'h100,    11'h000, 4'b0000, 8'h80, 8'h7F, 8'h01, 3'd0, 21'h102,    1'b1, 1'b0, 8'd5},
    '{5'd12, 21'h100,    11'h000, 4'b0000, 8'h80, 8'h80, 8'h01, 3'd0, 21'h102,    1'b0, 1'b0, 8'd5},
    '{5'd13, 21'h100,    11'h000, 4'b0000, 8'h7F, 8'h80, 8'h01, 3'd0, 21'h102,    1'b1, 1'b0, 8'd5},
    '{5'd13, 21'h100,    11'h000, 4'b0000, 8'h80, 8'h7F, 8'h01, 3'd0, 21'h102,    1'b0, 1'b0, 8'd5},
    // R6 counters
    '{5'd14, 21'h100,    11'h000, 4'b0000, 8'h01, 8'h00, 8'h00, 3'd0, 21'h102,    1'b1, 1'b0, 8'd6},
    '{5'd14, 21'h100,    11'h000, 4'b0000, 8'h02, 8'h00, 8'h01, 3'd0, 21'h102,    1'b0, 1'b0, 8'd6},
    '{5'd15, 21'h100,    11'h000, 4'b0000, 8'h00, 8'h00, 8'hFF, 3'd0, 21'h102,    1'b1, 1'b0, 8'd6},
    '{5'd16, 21'h100,    11'h000, 4'b0000, 8'hFF, 8'h00, 8'h00, 3'd0, 21'h102,    1'b1, 1'b0, 8'd6},
    '{5'd17, 21'h100,    11'h000, 4'b0000, 8'hFF, 8'h00, 8'h00, 3'd0, 21'h102,    1'b0, 1'b0, 8'd6},
    // R7 file test and bit tests
    '{5'd18, 21'h100,    11'h000, 4'b0000, 8'h00, 8'h11, 8'h01, 3'd0, 21'h102,    1'b1, 1'b0, 8'd7},
    '{5'd18, 21'h100,    11'h000, 4'b0000, 8'h01, 8'h11, 8'h01, 3'd0, 21'h102,    1'b0, 1'b0, 8'd7},
    '{5'd19, 21'h100,    11'h000, 4'b0000, 8'hF7, 8'h00, 8'h01, 3'd3, 21'h102,    1'b1, 1'b0, 8'd7},
    '{5'd19, 21'h100,    11'h000, 4'b0000, 8'h08, 8'h00, 8'h01, 3'd3, 21'h102,    1'b0, 1'b0, 8'd7},
    '{5'd20, 21'h100,    11'h000, 4'b0000, 8'h80, 8'h00, 8'h01, 3'd7, 21'h102,    1'b1, 1'b0, 8'd7},
    '{5'd20, 21'h100,    11'h000, 4'b0000, 8'h7F, 8'h00, 8'h01, 3'd7, 21'h102,    1'b0, 1'b0, 8'd7},
    // R9 plain advance, skip-friendly operands ignored
    '{5'd0,  21'h50,     11'h010, 4'b1111, 8'h00, 8'h00, 8'h00, 3'd0, 21'h52,     1'b0, 1'b0, 8'd9}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [4:0]    op_i = '0;
  logic [AW-1:0] pc_i = '0;
  logic [10:0]   off_i = '0;
  logic [3:0]    flags_i = '0;
  logic [DW-1:0] file_i = '0, wreg_i = '0, cnt_i = '0;
  logic [2:0]    bit_sel_i = '0;
  logic          valid_o, skip_o, push_o;
  logic [AW-1:0] next_pc_o, ret_addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pc_npc_top u_pc_npc_top (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .pc_i(pc_i),
    .off_i(off_i), .flags_i(flags_i), .file_i(file_i), .wreg_i(wreg_i),
    .cnt_i(cnt_i), .bit_sel_i(bit_sel_i), .valid_o(valid_o),
    .next_pc_o(next_pc_o), .skip_o(skip_o), .push_o(push_o),
    .ret_addr_o(ret_addr_o)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid", 32'(valid_o), 0);
    chk("R10 pc", 32'(next_pc_o), 0);
    chk("R10 skip/push", 32'({skip_o, push_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      valid_i = 1'b1; op_i = VECS[i].op; pc_i = VECS[i].pc; off_i = VECS[i].off;
      flags_i = VECS[i].fl; file_i = VECS[i].file; wreg_i = VECS[i].w;
      cnt_i = VECS[i].cnt; bit_sel_i = VECS[i].bsel;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d pc", VECS[i].rq, i), 32'(next_pc_o), 32'(VECS[i].epc));
      chk($sformatf("R%0d vec%0d skip", VECS[i].rq, i), 32'(skip_o), 32'(VECS[i].eskip));
      chk($sformatf("R%0d vec%0d push", VECS[i].rq, i), 32'(push_o), 32'(VECS[i].epush));
      if (VECS[i].epush)
        chk($sformatf("R4 vec%0d ret", i), 32'(ret_addr_o), 32'(VECS[i].pc + 21'd2));
    end

    // R9 unused code advances, no strobe
    op_i = 5'd25; pc_i = 21'h700; off_i = 11'h7FF; file_i = 8'h00; wreg_i = 8'h00; cnt_i = 8'h00;
    @(negedge clk);
    chk("R9 unused pc", 32'(next_pc_o), 32'h702);
    chk("R9 unused strobes", 32'({skip_o, push_o}), 0);

    // R10 latency: call then idle, result tied to sampling edge
    op_i = 5'd10; pc_i = 21'h900; off_i = 11'h001;
    @(posedge clk); #1;
    chk("R10 latency push", 32'(push_o), 1);
    chk("R10 latency pc", 32'(next_pc_o), 32'h904);
    @(negedge clk);

    // R9 idle holds and stays quiet
    valid_i = 1'b0; op_i = 5'd11; pc_i = 21'h1234; file_i = 8'h3; wreg_i = 8'h3;
    @(negedge clk);
    chk("R9 idle valid", 32'(valid_o), 0);
    chk("R9 idle strobes", 32'({skip_o, push_o}), 0);
    chk("R9 idle hold", 32'(next_pc_o), 32'h904);

    // R10 asynchronous reset mid-run
    valid_i = 1'b1; op_i = 5'd9; pc_i = 21'h40; off_i = 11'h004;
    @(negedge clk);
    chk("R1 pre-reset pc", 32'(next_pc_o), 32'h4A);
    #1 rst_ni = 1'b0;
    #1;
    chk("R10 async pc", 32'(next_pc_o), 0);
    chk("R10 async valid", 32'(valid_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule